// File: doc/BRIEF.md
# Multiprocessor-Aware Serial Receiver

This block receives asynchronous serial characters on a single input line and hands each finished character to a host through a small register-style interface. A one-cycle strobe at sixteen times the bit rate paces the receiver. The receiver synchronises the line, detects a start bit, and samples every following bit at mid-bit with a three-sample majority vote. It assembles the data bits and an optional parity bit. When the multiprocessor format is on, it also takes in one extra address-marker bit. The finished character moves into a data holding register. Status flags report data present, overrun, framing error and parity error. Two interrupt outputs report data ready and error, and a single enable bit gates both.

In multiprocessor format the host can arm a wake-up filter. While the filter is armed, frames whose marker bit is 0 are dropped whole: the data register is not written, no flag is set and no interrupt is raised. The first frame whose marker bit is 1 gets through and disarms the filter, so the host can listen only for address frames and then take the data frames that follow. The block also drives an output telling the pad logic whether the receiver owns the input pin.

The frame state machine has six states:
- S_IDLE: waits for a low line.
- S_START: checks the start bit at its half-bit point. A vote of 1 takes the transition back to S_IDLE as a false start. Otherwise the machine goes on to S_DATA at the end of the bit.
- S_DATA: shifts in the data bits. After the last one it goes to S_PAR if parity is on, else to S_MPB if the multiprocessor format is on, else to S_STOP.
- S_PAR: takes the parity bit, then goes to S_MPB or S_STOP.
- S_MPB: takes the marker bit, then goes to S_STOP.
- S_STOP: samples the stop bit at mid-bit, reports the frame and returns to S_IDLE.

Clearing the receive enable forces the machine to S_IDLE from any state.

Top module: `mpuart_rx`

## Requirements
- R1: After reset, all control bits, all status bits, the pin-ownership output and both interrupt outputs are 0.
- R2: The frame order is: a start bit (0); the data bits, least significant first; a parity bit when ctrl bit 4 is 1; a marker bit when ctrl bit 2 is 1; one stop bit. A completed frame loads the data register and sets status bit 0 (data present). Status bit 4 takes the frame's marker bit, and reads 0 when the format is off.
- R3: With parity on, a parity bit that does not match sets status bit 3. Even parity (ctrl bit 5 = 0) makes the count of ones over data plus parity even. Odd parity (ctrl bit 5 = 1) makes that count odd.
- R4: A stop bit sampled as 0 sets status bit 2 (framing error), and the data is still transferred.
- R5: If a frame completes while status bit 0 is still 1, status bit 1 (overrun) is set and the data register keeps its old contents.
- R6: irq_rx is 1 exactly when ctrl bit 1 and status bit 0 are both 1. irq_err is 1 exactly when ctrl bit 1 is 1 and any of status bits 1 to 3 is 1.
- R7: rx_pin_own follows ctrl bit 0 (receive enable). While that bit is 0, a frame on the line changes neither the data register nor any status bit.
- R8: With ctrl bits 2 and 3 both 1, a frame whose marker bit is 0 leaves the data register and all status bits unchanged and raises no interrupt.
- R9: With the filter armed, a frame whose marker bit is 1 is received normally and clears ctrl bit 3. Frames after it are received whatever their marker bit.
- R10: With ctrl bit 2 at 0, ctrl bit 3 has no effect and every frame is received.
- R11: Writing stat_wd with a bit at 0 clears the matching flag (bit 0 data present, bit 1 overrun, bit 2 framing, bit 3 parity). A bit at 1 leaves that flag alone. A data_rd pulse clears status bit 0.
- R12: A low pulse on the line that ends before the half-bit vote is rejected as a false start. It produces no frame, and the next real frame is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Strobe at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wd | input | 6 | Control data: bit 0 receive enable, bit 1 interrupt enable, bit 2 multiprocessor format, bit 3 wake-up filter, bit 4 parity on, bit 5 odd parity |
| stat_we | input | 1 | Write strobe for status clearing |
| stat_wd | input | 4 | Clear mask: a 0 clears data present, overrun, framing or parity (bits 0 to 3) |
| data_rd | input | 1 | Data register read strobe |
| ctrl_q | output | 6 | Control register readback |
| rx_data | output | DW | Received data register |
| rx_stat | output | 5 | Status: bit 0 data present, 1 overrun, 2 framing, 3 parity, 4 marker bit |
| rx_pin_own | output | 1 | Receiver owns the input pin |
| irq_rx | output | 1 | Data-ready interrupt |
| irq_err | output | 1 | Receive-error interrupt |

## Verification
The bench aims at the wake-up filter on both sides of its gate. A filter that leaks would set data present or change the data register on a frame with marker 0. A filter that does not disarm itself would drop the data frames that follow the address frame. A filter that ignores the format bit would drop ordinary frames. The bench also covers overrun: a design that overwrites the data register there would show the second character instead of the first. It checks that status writes with bits at 1 leave flags set, and that a short low glitch is rejected rather than read as a start bit that frames a bogus 0xFF character.

// File: rtl/mprx_pkg.sv
package mprx_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PAR, S_MPB, S_STOP
    } rx_state_e;

    typedef struct packed {
        logic par_odd;  // bit 5
        logic par_en;   // bit 4
        logic wake;     // bit 3
        logic mp_fmt;   // bit 2
        logic irq_en;   // bit 1
        logic rx_on;    // bit 0
    } rx_ctrl_t;

    localparam int CTRL_W = $bits(rx_ctrl_t);
endpackage

// File: rtl/mprx_sync_vote.sv
module mprx_sync_vote (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rxd,
    output logic rx_s,
    output logic vote
);
    logic [1:0] sync_q;
    logic [2:0] smp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            smp_q  <= '1;
        end else begin
            sync_q <= {sync_q[0], rxd};
            if (tick) smp_q <= {smp_q[1:0], sync_q[1]};
        end
    end

    assign rx_s = sync_q[1];
    assign vote = (smp_q[0] & smp_q[1]) | (smp_q[0] & smp_q[2]) | (smp_q[1] & smp_q[2]);
endmodule

// File: rtl/mprx_fsm.sv
module mprx_fsm #(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          rx_s,
    input  logic          vote,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          mp_fmt,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          mpb,
    output logic          frm_err,
    output logic          par_err
);
    import mprx_pkg::*;

    localparam int CW  = $clog2(OSR);
    localparam int BW  = (DW > 1) ? $clog2(DW) : 1;
    localparam int MID = OSR / 2;

    rx_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic [BW-1:0]   idx_q;
    logic [DW-1:0]   sh_q;
    logic            par_bit_q;
    logic            at_mid, at_end;

    assign at_mid = tick && (cnt_q == CW'(MID));
    assign at_end = tick && (cnt_q == CW'(OSR - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (tick && !rx_s) state_d = S_START;
            S_START: if (at_mid && vote) state_d = S_IDLE;
                     else if (at_end) state_d = S_DATA;
            S_DATA:  if (at_end && idx_q == BW'(DW - 1))
                         state_d = par_en ? S_PAR : (mp_fmt ? S_MPB : S_STOP);
            S_PAR:   if (at_end) state_d = mp_fmt ? S_MPB : S_STOP;
            S_MPB:   if (at_end) state_d = S_STOP;
            S_STOP:  if (at_mid) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
        if (!en) state_d = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0; idx_q <= '0; sh_q <= '0; par_bit_q <= 1'b0;
            mpb <= 1'b0; frm_err <= 1'b0; par_err <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state_q == S_IDLE) begin
                cnt_q <= '0;
                idx_q <= '0;
            end else if (tick) begin
                cnt_q <= (cnt_q == CW'(OSR - 1)) ? '0 : cnt_q + 1'b1;
            end
            if (state_q == S_DATA && at_end) idx_q <= idx_q + 1'b1;
            if (at_mid) begin
                unique case (state_q)
                    S_START: mpb <= 1'b0;
                    S_DATA:  sh_q <= {vote, sh_q[DW-1:1]};
                    S_PAR:   par_bit_q <= vote;
                    S_MPB:   mpb <= vote;
                    S_STOP: begin
                        frm_err <= !vote;
                        par_err <= par_en && (par_bit_q != ((^sh_q) ^ par_odd));
                        done    <= en;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign data = sh_q;

    // R2: a frame report lasts exactly one cycle
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: disabling the receiver drops it to idle
    p_off_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == S_IDLE));
    // R12: the bit counter is parked while idle
    p_idle_cnt_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && $past(state_q) == S_IDLE) |-> (cnt_q == '0));
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          rxd,
    input  logic          ctrl_we,
    input  logic [5:0]    ctrl_wd,
    input  logic          stat_we,
    input  logic [3:0]    stat_wd,
    input  logic          data_rd,
    output logic [5:0]    ctrl_q,
    output logic [DW-1:0] rx_data,
    output logic [4:0]    rx_stat,
    output logic          rx_pin_own,
    output logic          irq_rx,
    output logic          irq_err
);
    import mprx_pkg::*;

    rx_ctrl_t      ctrl;
    logic          full, ovr, frm, par, mpb_s;
    logic [DW-1:0] rdr;
    logic          rx_s, vote;
    logic          f_done, f_mpb, f_frm, f_perr;
    logic [DW-1:0] f_data;
    logic          gate, discard, wake_hit;

    mprx_sync_vote u_sync (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd),
        .rx_s(rx_s), .vote(vote)
    );

    mprx_fsm #(.DW(DW), .OSR(OSR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .en(ctrl.rx_on),
        .rx_s(rx_s), .vote(vote), .par_en(ctrl.par_en), .par_odd(ctrl.par_odd),
        .mp_fmt(ctrl.mp_fmt), .done(f_done), .data(f_data), .mpb(f_mpb),
        .frm_err(f_frm), .par_err(f_perr)
    );

    assign gate     = ctrl.mp_fmt && ctrl.wake;
    assign discard  = f_done && gate && !f_mpb;
    assign wake_hit = f_done && gate && f_mpb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0; rdr <= '0;
            full <= 1'b0; ovr <= 1'b0; frm <= 1'b0; par <= 1'b0; mpb_s <= 1'b0;
        end else begin
            if (ctrl_we)       ctrl <= rx_ctrl_t'(ctrl_wd);
            else if (wake_hit) ctrl.wake <= 1'b0;
            if (stat_we) begin
                full <= full & stat_wd[0];
                ovr  <= ovr  & stat_wd[1];
                frm  <= frm  & stat_wd[2];
                par  <= par  & stat_wd[3];
            end
            if (data_rd) full <= 1'b0;
            if (f_done && !discard) begin
                if (full) begin
                    ovr <= 1'b1;
                end else begin
                    rdr   <= f_data;
                    mpb_s <= f_mpb;
                    full  <= 1'b1;
                    if (f_frm)  frm <= 1'b1;
                    if (f_perr) par <= 1'b1;
                end
            end
        end
    end

    assign ctrl_q     = ctrl;
    assign rx_data    = rdr;
    assign rx_stat    = {mpb_s, par, frm, ovr, full};
    assign rx_pin_own = ctrl.rx_on;
    assign irq_rx     = ctrl.irq_en && full;
    assign irq_err    = ctrl.irq_en && (ovr || frm || par);

    // R5: overrun sets its flag and leaves the held character alone
    p_ovr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (f_done && !discard && full && !stat_we) |=> (rx_stat[1] && $stable(rx_data)));
    // R8: a filtered frame touches no status bit and no data
    p_wake_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (discard && !stat_we && !data_rd) |=> ($stable(rx_stat) && $stable(rx_data)));
    // R9: an accepted marker frame disarms the filter
    p_wake_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_hit && !ctrl_we) |=> !ctrl_q[3]);
    // R11: an all-ones clear mask leaves the error flags in place
    p_keep_ones_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && (&stat_wd) && !data_rd && !f_done) |=> $stable(rx_stat));
endmodule

// File: tb/tb_mpuart_rx.sv
module tb_mpuart_rx;
    localparam int CLK_PERIOD = 10;
    localparam int OSR = 16;
    localparam int NV  = 7;
    // vector: cfg[21:16] data[15:8] mpb[7] badpar[6] stop[5] exp_stat[4:0]
    localparam logic [21:0] VEC [NV] = '{
        {6'b000001, 8'hA5, 1'b0, 1'b0, 1'b1, 5'b00001},  // R2 plain
        {6'b010001, 8'h3C, 1'b0, 1'b0, 1'b1, 5'b00001},  // R3 even, good
        {6'b110001, 8'h81, 1'b0, 1'b1, 1'b1, 5'b01001},  // R3 odd, bad
        {6'b000001, 8'h5A, 1'b0, 1'b0, 1'b0, 5'b00101},  // R4 stop 0
        {6'b000101, 8'hC3, 1'b1, 1'b0, 1'b1, 5'b10001},  // R2 marker 1
        {6'b010101, 8'h0F, 1'b0, 1'b0, 1'b1, 5'b00001},  // R2 parity + marker
        {6'b001001, 8'h77, 1'b0, 1'b0, 1'b1, 5'b00001}   // R10 filter w/o format
    };

    logic clk = 0, rst_n = 0, rxd = 1;
    logic ctrl_we = 0, stat_we = 0, data_rd = 0;
    logic [5:0] ctrl_wd = '0;
    logic [3:0] stat_wd = '0;
    logic [5:0] ctrl_q;
    logic [7:0] rx_data;
    logic [4:0] rx_stat;
    logic rx_pin_own, irq_rx, irq_err;
    int checks = 0, errors = 0;
    logic [5:0] cur_cfg = '0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpuart_rx #(.DW(8), .OSR(OSR)) dut (
        .clk(clk), .rst_n(rst_n), .tick16(1'b1), .rxd(rxd),
        .ctrl_we(ctrl_we), .ctrl_wd(ctrl_wd), .stat_we(stat_we), .stat_wd(stat_wd),
        .data_rd(data_rd), .ctrl_q(ctrl_q), .rx_data(rx_data), .rx_stat(rx_stat),
        .rx_pin_own(rx_pin_own), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [5:0] v);
        @(negedge clk); ctrl_we = 1; ctrl_wd = v; cur_cfg = v;
        @(negedge clk); ctrl_we = 0;
    endtask

    task automatic wr_stat(input logic [3:0] v);
        @(negedge clk); stat_we = 1; stat_wd = v;
        @(negedge clk); stat_we = 0;
    endtask

    task automatic rd_data();
        @(negedge clk); data_rd = 1;
        @(negedge clk); data_rd = 0;
    endtask

    task automatic bit_out(input logic b);
        @(negedge clk); rxd = b;
        repeat (OSR - 1) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic mpb, input logic badpar, input logic stop);
        logic pb;
        pb = (^d) ^ cur_cfg[5] ^ badpar;
        bit_out(1'b0);
        for (int i = 0; i < 8; i++) bit_out(d[i]);
        if (cur_cfg[4]) bit_out(pb);
        if (cur_cfg[2]) bit_out(mpb);
        bit_out(stop);
        @(negedge clk); rxd = 1;
        repeat (2 * OSR) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(rx_stat, 5'b0, "R1 status");
        chk(ctrl_q, 6'b0, "R1 ctrl");
        chk({rx_pin_own, irq_rx, irq_err}, 3'b0, "R1 pin/irq");

        // table walk: R2 R3 R4 R10
        for (int v = 0; v < NV; v++) begin
            wr_ctrl(VEC[v][21:16]);
            send(VEC[v][15:8], VEC[v][7], VEC[v][6], VEC[v][5]);
            chk(rx_data, VEC[v][15:8], $sformatf("R2 data vec%0d", v));
            chk(rx_stat, VEC[v][4:0], $sformatf("R2/R3/R4/R10 status vec%0d", v));
            wr_stat(4'b0000);
            rd_data();
        end

        // R7 receiver off: pin released, frame ignored
        wr_ctrl(6'b000000);
        chk(rx_pin_own, 1'b0, "R7 pin off");
        send(8'h3E, 1'b0, 1'b0, 1'b1);
        chk(rx_stat, 5'b0, "R7 status unchanged");
        chk(rx_data, 8'h77, "R7 data unchanged");
        wr_ctrl(6'b000001);
        chk(rx_pin_own, 1'b1, "R7 pin on");

        // R5 overrun
        send(8'h11, 1'b0, 1'b0, 1'b1);
        send(8'h22, 1'b0, 1'b0, 1'b1);
        chk(rx_stat, 5'b00011, "R5 overrun flag");
        chk(rx_data, 8'h11, "R5 data kept");

        // R11 clear semantics
        wr_stat(4'b1111);
        chk(rx_stat, 5'b00011, "R11 ones keep");
        wr_stat(4'b1101);
        chk(rx_stat, 5'b00001, "R11 clear overrun only");
        rd_data();
        chk(rx_stat, 5'b00000, "R11 read clears full");

        // R6 interrupt gating
        wr_ctrl(6'b000011);
        send(8'h99, 1'b0, 1'b0, 1'b1);
        chk({irq_rx, irq_err}, 2'b10, "R6 rx irq");
        wr_ctrl(6'b000001);
        chk({irq_rx, irq_err}, 2'b00, "R6 disabled");
        wr_stat(4'b0000); rd_data();
        wr_ctrl(6'b000011);
        send(8'h42, 1'b0, 1'b0, 1'b0);
        chk({irq_rx, irq_err}, 2'b11, "R6 err irq");
        wr_stat(4'b0000); rd_data();

        // R8 filter drops marker-0 frame
        wr_ctrl(6'b001101);
        send(8'hE7, 1'b0, 1'b0, 1'b1);
        chk(rx_stat, 5'b0, "R8 status untouched");
        chk(rx_data, 8'h42, "R8 data untouched");
        chk({irq_rx, irq_err}, 2'b00, "R8 no irq");
        chk(ctrl_q, 6'b001101, "R8 filter still armed");

        // R9 marker-1 frame accepted, filter disarms
        send(8'hA1, 1'b1, 1'b0, 1'b1);
        chk(rx_stat, 5'b10001, "R9 accepted status");
        chk(rx_data, 8'hA1, "R9 data");
        chk(ctrl_q, 6'b000101, "R9 filter cleared");
        wr_stat(4'b0000); rd_data();
        send(8'h5C, 1'b0, 1'b0, 1'b1);
        chk(rx_stat, 5'b00001, "R9 later frame");
        chk(rx_data, 8'h5C, "R9 later data");
        wr_stat(4'b0000); rd_data();

        // R12 glitch rejected, real frame after it
        wr_ctrl(6'b000001);
        @(negedge clk); rxd = 0;
        repeat (3) @(negedge clk);
        rxd = 1;
        repeat (4 * OSR) @(negedge clk);
        chk(rx_stat, 5'b0, "R12 glitch ignored");
        send(8'h6B, 1'b0, 1'b0, 1'b1);
        chk(rx_data, 8'h6B, "R12 next frame data");
        chk(rx_stat, 5'b00001, "R12 next frame status");

        if (!done_flag) begin
            done_flag = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_flag) begin
            done_flag = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule